// File: doc/BRIEF.md
# Hardware Cursor Overlay Generator

This block draws a small two-plane cursor over the display raster. The host writes two row planes into the block: a visibility plane and a colour-select plane. Each has one word per cursor row. The host also writes a packed position word and a control word that holds the video-enable bit. The pixel pipeline drives the current beam coordinates every cycle. Two cycles later the block returns a 2-bit overlay code. The code tells the palette stage whether the cursor covers that pixel, and if so whether the foreground or the background overlay colour is shown.

A position write is held as pending and is copied into the active position only when a frame-start pulse arrives, so a cursor cannot tear in the middle of a frame. A reserved coordinate value in both halves of the position word hides the cursor. Clearing the video-enable bit blanks the output. Hotspot correction is done by the host, and colour lookup is done downstream.

Top module: `cursor_overlay`

## Requirements
- R1: Host writes with `wr_sel`=0 store `wr_data[31:0]` as visibility-plane row `wr_addr`. Writes with `wr_sel`=1 store it as colour-plane row `wr_addr`. Rows 0..31 run from top to bottom.
- R2: `ovl_code` is 0 when the pixel is not covered, 1 when the visibility bit is 1 and the colour bit is 0 (background), and 3 when both bits are 1 (foreground). A visibility bit of 0 gives 0 whatever the colour bit is. The code 2 never appears.
- R3: Within a row word, bit 31 is the leftmost pixel. Cursor column c reads bit 31-c, so clearing the low-order bits narrows the cursor.
- R4: A `wr_sel`=2 write loads the position word. X is in bits 31:16 and Y is in bits 15:0. Each is a signed 16-bit coordinate of the top-left cursor pixel, so a negative value clips the cursor at the screen edge.
- R5: A beam pixel (bx, by) can be covered only when bx-X and by-Y both lie in 0..31. The row read is by-Y and the column read is bx-X.
- R6: A position word of 0x80008000 (X and Y both 0x8000) hides the cursor. `ovl_code` is then 0 for every beam position.
- R7: A position write takes effect only on a cycle where `frame_start` is high. Until then the previous active position stays in use.
- R8: A `wr_sel`=3 write sets video enable to `wr_data[0]`. `video_on` shows the new value on the cycle after the write. While video is disabled, `ovl_code` is forced to 0.
- R9: Synchronous reset clears video enable, sets both the active and pending positions to the hidden value, and drives `ovl_code` and `video_on` to 0.
- R10: `ovl_code` reflects the beam coordinates presented two clock edges earlier.

Ports are listed in the order of the port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host register write strobe |
| wr_sel | input | 2 | Write target: 0 visibility plane, 1 colour plane, 2 position, 3 control |
| wr_addr | input | 5 | Row index for plane writes |
| wr_data | input | 32 | Write data |
| frame_start | input | 1 | One-cycle pulse at the start of a frame |
| beam_x | input | 16 | Current beam column (unsigned) |
| beam_y | input | 16 | Current beam line (unsigned) |
| ovl_code | output | 2 | Overlay code: 0 none, 1 background, 3 foreground |
| video_on | output | 1 | Video enable; low means the display is blanked |

## Verification
The most likely fault is an active position that drifts or swaps before a frame-start pulse. It shows up as cursor hits at the old coordinates turning into misses, or the reverse, at the very next pixel sampled, two cycles after that beam value. A plane row stored at the wrong index, or a bit order that runs the wrong way, gives the wrong code only at particular row and column pairs. The bench therefore probes the window edges, columns on both sides of the narrowed width, and rows with different colour patterns. A stale video-enable flop shows on `video_on` one cycle after the control write.

// File: rtl/cursor_ovl_pkg.sv
package cursor_ovl_pkg;
  typedef enum logic [1:0] {
    SEL_VIS  = 2'd0,
    SEL_CLR  = 2'd1,
    SEL_POS  = 2'd2,
    SEL_CTRL = 2'd3
  } wr_target_e;

  localparam logic [1:0] CODE_NONE = 2'd0;
  localparam logic [1:0] CODE_BG   = 2'd1;
  localparam logic [1:0] CODE_FG   = 2'd3;

  function automatic logic [1:0] overlay_code(input logic vis, input logic clr);
    if (!vis) return CODE_NONE;
    return clr ? CODE_FG : CODE_BG;
  endfunction
endpackage

// File: rtl/cursor_plane_ram.sv
module cursor_plane_ram #(
  parameter int ROWS  = 32,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] store [ROWS];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/cursor_pos_reg.sv
module cursor_pos_reg #(
  parameter int COORD_W = 16,
  parameter logic [COORD_W-1:0] HIDE = 16'h8000,
  localparam int PW = 2 * COORD_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [PW-1:0] load_word,
  input  logic          frame_start,
  output logic [PW-1:0] act_pos,
  output logic          hidden
);
  localparam logic [PW-1:0] HIDE_WORD = {HIDE, HIDE};
  logic [PW-1:0] pend_pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_pos <= HIDE_WORD;
      act_pos  <= HIDE_WORD;
    end else begin
      if (load) pend_pos <= load_word;
      if (frame_start) act_pos <= load ? load_word : pend_pos;
    end
  end

  assign hidden = (act_pos == HIDE_WORD);
endmodule

// File: rtl/cursor_hit_calc.sv
module cursor_hit_calc #(
  parameter int CUR_DIM = 32,
  parameter int COORD_W = 16,
  localparam int AW = $clog2(CUR_DIM),
  localparam int DW = COORD_W + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [COORD_W-1:0] beam_x,
  input  logic [COORD_W-1:0] beam_y,
  input  logic [COORD_W-1:0] pos_x,
  input  logic [COORD_W-1:0] pos_y,
  input  logic               hidden,
  output logic [AW-1:0]      row_idx,
  output logic               hit_q,
  output logic [AW-1:0]      col_q
);
  logic signed [DW-1:0] dx, dy;
  logic in_x, in_y;

  always_comb begin
    dx = $signed({2'b00, beam_x}) - $signed({{2{pos_x[COORD_W-1]}}, pos_x});
    dy = $signed({2'b00, beam_y}) - $signed({{2{pos_y[COORD_W-1]}}, pos_y});
    in_x = (dx[DW-1:AW] == '0);
    in_y = (dy[DW-1:AW] == '0);
    row_idx = dy[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q <= 1'b0;
      col_q <= '0;
    end else begin
      hit_q <= in_x && in_y && !hidden;
      col_q <= dx[AW-1:0];
    end
  end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
  parameter int CUR_DIM = 32,
  parameter int COORD_W = 16,
  parameter logic [COORD_W-1:0] HIDE = 16'h8000,
  localparam int AW = $clog2(CUR_DIM),
  localparam int BUS_W = 2 * COORD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [AW-1:0]    wr_addr,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             frame_start,
  input  logic [COORD_W-1:0] beam_x,
  input  logic [COORD_W-1:0] beam_y,
  output logic [1:0]       ovl_code,
  output logic             video_on
);
  import cursor_ovl_pkg::*;

  logic [BUS_W-1:0]   act_pos;
  logic               hidden;
  logic [AW-1:0]      row_idx, col_q;
  logic               hit_q;
  logic [CUR_DIM-1:0] plane_q [2];
  logic               viden_q;

  genvar p;
  generate
    for (p = 0; p < 2; p++) begin : g_plane
      cursor_plane_ram #(.ROWS(CUR_DIM), .WIDTH(CUR_DIM)) u_ram (
        .clk  (clk),
        .we   (wr_en && (wr_sel == 2'(p))),
        .waddr(wr_addr),
        .wdata(wr_data[CUR_DIM-1:0]),
        .raddr(row_idx),
        .rdata(plane_q[p])
      );
    end
  endgenerate

  cursor_pos_reg #(.COORD_W(COORD_W), .HIDE(HIDE)) u_pos (
    .clk        (clk),
    .rst        (rst),
    .load       (wr_en && (wr_sel == SEL_POS)),
    .load_word  (wr_data),
    .frame_start(frame_start),
    .act_pos    (act_pos),
    .hidden     (hidden)
  );

  cursor_hit_calc #(.CUR_DIM(CUR_DIM), .COORD_W(COORD_W)) u_hit (
    .clk    (clk),
    .rst    (rst),
    .beam_x (beam_x),
    .beam_y (beam_y),
    .pos_x  (act_pos[BUS_W-1:COORD_W]),
    .pos_y  (act_pos[COORD_W-1:0]),
    .hidden (hidden),
    .row_idx(row_idx),
    .hit_q  (hit_q),
    .col_q  (col_q)
  );

  always_ff @(posedge clk) begin
    if (rst) viden_q <= 1'b0;
    else if (wr_en && wr_sel == SEL_CTRL) viden_q <= wr_data[0];
  end

  logic [AW-1:0] bit_sel;
  logic [1:0]    code_next;
  always_comb begin
    bit_sel   = AW'(CUR_DIM - 1) - col_q;
    code_next = hit_q ? overlay_code(plane_q[SEL_VIS][bit_sel], plane_q[SEL_CLR][bit_sel])
                      : CODE_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) ovl_code <= CODE_NONE;
    else     ovl_code <= viden_q ? code_next : CODE_NONE;
  end

  assign video_on = viden_q;
endmodule

// File: rtl/cursor_overlay_checker.sv
module cursor_overlay_checker (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [1:0]  wr_sel,
  input logic [31:0] wr_data,
  input logic        frame_start,
  input logic [1:0]  ovl_code,
  input logic        video_on,
  input logic [31:0] act_pos,
  input logic        hit_q
);
  // R2: code 2 is never produced
  a_r2_no_code_two: assert property (@(posedge clk) disable iff (rst)
    ovl_code != 2'b10);

  // R8: blanking forces the overlay code to zero
  a_r8_blank_gates: assert property (@(posedge clk) disable iff (rst)
    !$past(video_on) |-> ovl_code == 2'b00);

  // R8: control write lands on video_on one cycle later
  a_r8_ctrl_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd3) |=> video_on == $past(wr_data[0]));

  // R7: active position holds between frame starts
  a_r7_pos_hold: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(act_pos));

  // R6: hidden position never yields a window hit
  a_r6_hidden_no_hit: assert property (@(posedge clk) disable iff (rst)
    (act_pos == 32'h8000_8000) |=> !hit_q);

  // R9: reset leaves outputs idle
  a_r9_reset_idle: assert property (@(posedge clk)
    rst |=> (ovl_code == 2'b00 && !video_on));
endmodule

bind cursor_overlay cursor_overlay_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .frame_start(frame_start),
  .ovl_code   (ovl_code),
  .video_on   (video_on),
  .act_pos    (act_pos),
  .hit_q      (hit_q)
);

// File: tb/test_cursor_overlay.sv
module test_cursor_overlay;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        frame_start = 1'b0;
  logic [15:0] beam_x = '0, beam_y = '0;
  logic [1:0]  ovl_code;
  logic        video_on;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cursor_overlay i_cursor_overlay (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
    .wr_data(wr_data), .frame_start(frame_start), .beam_x(beam_x),
    .beam_y(beam_y), .ovl_code(ovl_code), .video_on(video_on)
  );

  // beam x, beam y, expected code; cursor at (100,50)
  localparam int NV = 12;
  localparam logic [33:0] VEC [NV] = '{
    {16'd100, 16'd50, 2'd3},  // R3 col0 bit31, even row
    {16'd101, 16'd50, 2'd1},  // R2 background
    {16'd100, 16'd51, 2'd1},  // R1 odd row colour plane zero
    {16'd115, 16'd50, 2'd1},  // R3 last visible column
    {16'd116, 16'd50, 2'd0},  // R3 narrowed width
    {16'd131, 16'd50, 2'd0},  // R5 column 31 masked
    {16'd132, 16'd50, 2'd0},  // R5 right of window
    {16'd99,  16'd50, 2'd0},  // R5 left of window
    {16'd100, 16'd49, 2'd0},  // R5 above window
    {16'd100, 16'd81, 2'd0},  // R1 row 31 invisible
    {16'd100, 16'd82, 2'd0},  // R5 below window
    {16'd114, 16'd52, 2'd3}   // R3 bit 17 foreground
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] sel, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic frame_pulse();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic probe(input logic [15:0] x, input logic [15:0] y, output logic [1:0] c);
    @(negedge clk);
    beam_x = x; beam_y = y;
    @(posedge clk);
    @(posedge clk);
    #1 c = ovl_code;
  endtask

  initial begin
    logic [1:0] c;
    repeat (3) @(negedge clk);
    #1;
    check("R9 reset code", 32'(ovl_code), 0);
    check("R9 reset video", 32'(video_on), 0);
    rst = 1'b0;

    for (int r = 0; r < 32; r++) begin
      host_wr(2'd0, 5'(r), (r == 31) ? 32'h0 : 32'hFFFF_0000);
      host_wr(2'd1, 5'(r), (r % 2 == 0) ? 32'hAAAA_AAAA : 32'h0);
    end
    host_wr(2'd3, 0, 32'h1);
    #1 check("R8 video enabled", 32'(video_on), 1);

    probe(16'd100, 16'd50, c);
    check("R9 hidden after reset", 32'(c), 0);

    host_wr(2'd2, 0, 32'h0064_0032);
    probe(16'd100, 16'd50, c);
    check("R7 pending not active", 32'(c), 0);
    frame_pulse();

    for (int i = 0; i < NV; i++) begin
      probe(VEC[i][33:18], VEC[i][17:2], c);
      check($sformatf("R5/R2 vector %0d", i), 32'(c), 32'(VEC[i][1:0]));
    end

    // R10: output lags beam by two edges
    probe(16'd100, 16'd50, c);
    @(negedge clk);
    beam_x = 16'd0; beam_y = 16'd0;
    @(posedge clk); #1;
    check("R10 one edge still old", 32'(ovl_code), 3);
    @(posedge clk); #1;
    check("R10 two edges new", 32'(ovl_code), 0);

    // R4: negative x clips at left edge
    host_wr(2'd2, 0, 32'hFFFC_0000);
    frame_pulse();
    probe(16'd0, 16'd0, c);
    check("R4 negative x col4", 32'(c), 3);
    probe(16'd1, 16'd0, c);
    check("R4 negative x col5", 32'(c), 1);

    // R6: hidden value
    host_wr(2'd2, 0, 32'h8000_8000);
    frame_pulse();
    probe(16'd0, 16'd0, c);
    check("R6 hidden", 32'(c), 0);

    // R8: blanking
    host_wr(2'd2, 0, 32'h0064_0032);
    frame_pulse();
    host_wr(2'd3, 0, 32'h0);
    #1 check("R8 video off", 32'(video_on), 0);
    probe(16'd100, 16'd50, c);
    check("R8 blank forces zero", 32'(c), 0);
    host_wr(2'd3, 0, 32'h1);
    probe(16'd100, 16'd50, c);
    check("R8 re-enabled", 32'(c), 3);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule